// File: doc/BRIEF.md
# Home-Node Directory Access Filter

This block sits beside the home-node coherence engine and decides, for every incoming coherence request, which memory operations on the combined data-plus-directory line are really needed. It takes the request kind, whether the request comes from the local chip or from a remote node, the home L2 state of the line, the directory state and whether the requester is the recorded owner. From these it returns one registered decision: how much of the line to read for directory state, how the directory is to be written, whether the home L2 can provide the data, and whether the request is a stale race to be discarded.

The directory shares its check word with the data. A directory update therefore needs a check word that covers the data. The filter chooses, per request, between writing invented zero data, because memory will be stale anyway, and merging a partial check word saved at read time. The full line is never read a second time. When the home L2 holds a line that only the home node has cached, the directory is taken to be uncached and its read is skipped.

A decision appears one cycle after a request is accepted. It stays on the outputs until the consumer takes it, and no new request is accepted while it waits.

Top module: `hdf_dir_filter`

## Requirements
- R1: A request accepted with `req_valid` and `req_ready` high at a clock edge gives `dec_valid` high after that edge. `req_ready` is high exactly when no decision is pending, or when the pending decision is being taken (`dec_ready` high).
- R2: While `dec_valid` is high and `dec_ready` is low, `dec_valid` and all decision fields hold their values.
- R3: When the home L2 state is node-exclusive (`l2_state`=2), for any source and any legal kind, the read amount is none (`dec_rd_amt`=0). Every later choice treats the directory as uncached (state 0), with the owner match forced false.
- R4: Local requests (`req_remote`=0) to a line that is not node-exclusive read half a line (1) for RD and the full line (2) for RDEX, EX and ITOD. They read nothing for WB and REPL. Kind codes: RD=0, RDEX=1, EX=2, ITOD=3, WB=4, REPL=5.
- R5: Remote requests to a line that is not node-exclusive read the full line for RD, RDEX, EX and ITOD, and half a line for WB and REPL.
- R6: Local write kinds (`dec_wr_kind`: none=0, zero-data masked=1, partial-check masked=2, full=3) are as follows. RD and REPL write nothing. RDEX, EX and ITOD write zero-data masked when the effective directory state is not uncached, and nothing otherwise. WB writes full.
- R7: A remote RD writes partial-check masked when the effective directory is uncached (0) or shared (1 or 2). It writes zero-data masked when the directory is exclusive (3).
- R8: Remote RDEX, ITOD, REPL, and remote EX that is not dropped, write zero-data masked.
- R9: An EX whose effective directory state is exclusive is dropped (`dec_drop`=1), with no write, whatever its source.
- R10: A remote WB writes full only when the effective directory is exclusive and `dir_owner_hit` is 1. Otherwise it is dropped with no write.
- R11: `dec_l2_data` is 1 only for RD and RDEX when `l2_state` is valid (1) or node-exclusive (2). L2 state 0 and the reserved code 3 count as invalid.
- R12: Reserved kind codes 6 and 7 are dropped, with no read, no write and no L2 data.
- R13: After reset `dec_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 3 | Request kind code |
| req_remote | input | 1 | 1 when the request comes from a remote node |
| l2_state | input | 2 | Home L2 line state: 0 invalid, 1 valid, 2 node-exclusive |
| dir_state | input | 2 | Directory state: 0 uncached, 1/2 shared, 3 exclusive |
| dir_owner_hit | input | 1 | Requester equals the recorded exclusive owner |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_rd_amt | output | 2 | Directory read amount: 0 none, 1 half line, 2 full line |
| dec_wr_kind | output | 2 | Directory write kind |
| dec_l2_data | output | 1 | Home L2 provides the data |
| dec_drop | output | 1 | Request is discarded as stale |

## Verification
The assertions watch, on every cycle, the properties that hold across all inputs. These are the one-cycle acceptance-to-decision timing, holding steady under backpressure, no read for node-exclusive lines, no write or data on a drop, the partial-check write only for RD, the full write only for WB, and the drop of reserved codes. The exact read amount and write kind for each combination of kind, source, L2 state, directory state and owner match can only be shown by the bench. The bench sweeps all of these exhaustively and then random mixes with stall lengths.

// File: rtl/hdf_pkg.sv
package hdf_pkg;

    typedef enum logic [2:0] {
        REQ_RD   = 3'd0,
        REQ_RDEX = 3'd1,
        REQ_EX   = 3'd2,
        REQ_ITOD = 3'd3,
        REQ_WB   = 3'd4,
        REQ_REPL = 3'd5,
        REQ_RSV6 = 3'd6,
        REQ_RSV7 = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        L2_INV   = 2'd0,
        L2_VALID = 2'd1,
        L2_NEXCL = 2'd2,
        L2_RSV   = 2'd3
    } l2_state_e;

    typedef enum logic [1:0] {
        DIR_UNC     = 2'd0,
        DIR_SHR_PTR = 2'd1,
        DIR_SHR_VEC = 2'd2,
        DIR_EXCL    = 2'd3
    } dir_state_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_HALF = 2'd1,
        RD_FULL = 2'd2
    } rd_amt_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_DUMMY = 2'd1,
        WR_PECC  = 2'd2,
        WR_FULL  = 2'd3
    } wr_kind_e;

    typedef struct packed {
        rd_amt_e  rd;
        wr_kind_e wr;
        logic     l2_data;
        logic     drop;
    } decision_t;

    localparam int DEC_W = $bits(decision_t);

    function automatic logic kind_legal(req_kind_e k);
        return (k != REQ_RSV6) && (k != REQ_RSV7);
    endfunction

    function automatic dir_state_e effective_dir(l2_state_e l2, dir_state_e d);
        return (l2 == L2_NEXCL) ? DIR_UNC : d;
    endfunction

endpackage

// File: rtl/hdf_read_policy.sv
module hdf_read_policy
    import hdf_pkg::*;
(
    input  req_kind_e kind,
    input  logic      remote,
    input  l2_state_e l2,
    output rd_amt_e   rd_amt
);
    always_comb begin
        rd_amt = RD_NONE;
        if (kind_legal(kind) && l2 != L2_NEXCL) begin
            if (remote) begin
                case (kind)
                    REQ_WB, REQ_REPL: rd_amt = RD_HALF;
                    default:          rd_amt = RD_FULL;
                endcase
            end else begin
                case (kind)
                    REQ_RD:                     rd_amt = RD_HALF;
                    REQ_RDEX, REQ_EX, REQ_ITOD: rd_amt = RD_FULL;
                    default:                    rd_amt = RD_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/hdf_write_policy.sv
module hdf_write_policy
    import hdf_pkg::*;
(
    input  req_kind_e  kind,
    input  logic       remote,
    input  l2_state_e  l2,
    input  dir_state_e dir,
    input  logic       owner_hit,
    output wr_kind_e   wr_kind,
    output logic       l2_data,
    output logic       drop
);
    dir_state_e eff;
    logic       owner_eff;
    logic       remote_copy;

    assign eff         = effective_dir(l2, dir);
    assign owner_eff   = (l2 == L2_NEXCL) ? 1'b0 : owner_hit;
    assign remote_copy = (eff != DIR_UNC);

    always_comb begin
        wr_kind = WR_NONE;
        drop    = 1'b0;
        case (kind)
            REQ_RD: begin
                if (remote) wr_kind = (eff == DIR_EXCL) ? WR_DUMMY : WR_PECC;
            end
            REQ_RDEX, REQ_ITOD: begin
                if (remote || remote_copy) wr_kind = WR_DUMMY;
            end
            REQ_EX: begin
                if (eff == DIR_EXCL)            drop    = 1'b1;
                else if (remote || remote_copy) wr_kind = WR_DUMMY;
            end
            REQ_WB: begin
                if (!remote)                                wr_kind = WR_FULL;
                else if (eff == DIR_EXCL && owner_eff)      wr_kind = WR_FULL;
                else                                        drop    = 1'b1;
            end
            REQ_REPL: begin
                if (remote) wr_kind = WR_DUMMY;
            end
            default: drop = 1'b1;
        endcase
    end

    assign l2_data = ((kind == REQ_RD) || (kind == REQ_RDEX)) &&
                     ((l2 == L2_VALID) || (l2 == L2_NEXCL));
endmodule

// File: rtl/hdf_out_reg.sv
module hdf_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end
endmodule

// File: rtl/hdf_dir_filter.sv
module hdf_dir_filter
    import hdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [2:0] req_kind,
    input  logic       req_remote,
    input  logic [1:0] l2_state,
    input  logic [1:0] dir_state,
    input  logic       dir_owner_hit,
    output logic       dec_valid,
    input  logic       dec_ready,
    output logic [1:0] dec_rd_amt,
    output logic [1:0] dec_wr_kind,
    output logic       dec_l2_data,
    output logic       dec_drop
);
    req_kind_e  kind_t;
    l2_state_e  l2_t;
    dir_state_e dir_t;
    decision_t  nxt;
    decision_t  cur;
    logic [DEC_W-1:0] cur_bits;

    assign kind_t = req_kind_e'(req_kind);
    assign l2_t   = l2_state_e'(l2_state);
    assign dir_t  = dir_state_e'(dir_state);

    hdf_read_policy u_rd (
        .kind   (kind_t),
        .remote (req_remote),
        .l2     (l2_t),
        .rd_amt (nxt.rd)
    );

    hdf_write_policy u_wr (
        .kind      (kind_t),
        .remote    (req_remote),
        .l2        (l2_t),
        .dir       (dir_t),
        .owner_hit (dir_owner_hit),
        .wr_kind   (nxt.wr),
        .l2_data   (nxt.l2_data),
        .drop      (nxt.drop)
    );

    hdf_out_reg #(.W(DEC_W)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (nxt),
        .out_valid (dec_valid),
        .out_ready (dec_ready),
        .out_data  (cur_bits)
    );

    assign cur         = decision_t'(cur_bits);
    assign dec_rd_amt  = cur.rd;
    assign dec_wr_kind = cur.wr;
    assign dec_l2_data = cur.l2_data;
    assign dec_drop    = cur.drop;
endmodule

// File: rtl/hdf_dir_filter_chk.sv
module hdf_dir_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_kind,
    input logic [1:0] l2_state,
    input logic       dec_valid,
    input logic       dec_ready,
    input logic [1:0] dec_rd_amt,
    input logic [1:0] dec_wr_kind,
    input logic       dec_l2_data,
    input logic       dec_drop
);
    logic take;
    assign take = req_valid && req_ready;

    AST_ACCEPT_GIVES_DECISION: assert property (@(posedge clk) disable iff (rst)
        take |=> dec_valid); // R1

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |=>
        (dec_valid && $stable({dec_rd_amt, dec_wr_kind, dec_l2_data, dec_drop}))); // R2

    AST_NEXCL_SKIPS_READ: assert property (@(posedge clk) disable iff (rst)
        (take && l2_state == 2'd2) |=> (dec_rd_amt == 2'd0)); // R3

    AST_DROP_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_drop) |-> (dec_wr_kind == 2'd0 && !dec_l2_data)); // R9

    AST_PECC_ONLY_FOR_RD: assert property (@(posedge clk) disable iff (rst)
        (take && req_kind != 3'd0) |=> (dec_wr_kind != 2'd2)); // R7

    AST_FULL_WRITE_ONLY_WB: assert property (@(posedge clk) disable iff (rst)
        (take && req_kind != 3'd4) |=> (dec_wr_kind != 2'd3)); // R10

    AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (take && req_kind[2:1] == 2'b11) |=> (dec_drop && dec_rd_amt == 2'd0)); // R12
endmodule

bind hdf_dir_filter hdf_dir_filter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .l2_state    (l2_state),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_rd_amt  (dec_rd_amt),
    .dec_wr_kind (dec_wr_kind),
    .dec_l2_data (dec_l2_data),
    .dec_drop    (dec_drop)
);

// File: tb/tb_hdf_dir_filter.sv
`timescale 1ns/1ps
module tb_hdf_dir_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = '0;
    logic       req_remote = 1'b0;
    logic [1:0] l2_state = '0;
    logic [1:0] dir_state = '0;
    logic       dir_owner_hit = 1'b0;
    logic       dec_valid;
    logic       dec_ready = 1'b0;
    logic [1:0] dec_rd_amt;
    logic [1:0] dec_wr_kind;
    logic       dec_l2_data;
    logic       dec_drop;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hdf_dir_filter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_remote(req_remote), .l2_state(l2_state),
        .dir_state(dir_state), .dir_owner_hit(dir_owner_hit),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_rd_amt(dec_rd_amt),
        .dec_wr_kind(dec_wr_kind), .dec_l2_data(dec_l2_data), .dec_drop(dec_drop)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (kind=%0d remote=%0d l2=%0d dir=%0d own=%0d)",
                     tag, act, exp, req_kind, req_remote, l2_state, dir_state, dir_owner_hit);
        end
    endtask

    // expected {rd[1:0], wr[1:0], l2data, drop}
    function automatic logic [5:0] expect_dec(int k, int rem, int l2, int dir, int own);
        int rd, wr, ld, dr, ed, ow;
        bit nex;
        nex = (l2 == 2);
        ed  = nex ? 0 : dir;
        ow  = nex ? 0 : own;
        rd = 0; wr = 0; ld = 0; dr = 0;
        if (k > 5) return 6'b000001;                      // R12
        if (!nex) begin
            if (rem != 0) rd = (k == 4 || k == 5) ? 1 : 2; // R5
            else if (k == 0) rd = 1;                       // R4
            else if (k <= 3) rd = 2;
        end
        case (k)
            0: if (rem != 0) wr = (ed == 3) ? 1 : 2;       // R7
            1, 3: if (rem != 0 || ed != 0) wr = 1;         // R6 R8
            2: begin
                if (ed == 3) dr = 1;                       // R9
                else if (rem != 0 || ed != 0) wr = 1;
            end
            4: begin
                if (rem == 0) wr = 3;                      // R6
                else if (ed == 3 && ow != 0) wr = 3;       // R10
                else dr = 1;
            end
            default: if (rem != 0) wr = 1;                 // R8 (REPL)
        endcase
        ld = (k <= 1 && (l2 == 1 || l2 == 2)) ? 1 : 0;     // R11
        return {rd[1:0], wr[1:0], ld[0], dr[0]};
    endfunction

    function automatic string wr_tag(int k, int rem, int l2, int dir);
        int ed;
        ed = (l2 == 2) ? 0 : dir;
        if (k > 5) return "R12";
        if (k == 2 && ed == 3) return "R9";
        if (rem == 0) return "R6";
        if (k == 0) return "R7";
        if (k == 4) return "R10";
        return "R8";
    endfunction

    task automatic run_vec(int k, int rem, int l2, int dir, int own, int stall);
        logic [5:0] e;
        logic [5:0] got;
        string rtag;
        e = expect_dec(k, rem, l2, dir, own);
        rtag = (k > 5) ? "R12" : (l2 == 2) ? "R3" : (rem != 0) ? "R5" : "R4";
        @(negedge clk);
        req_kind = k[2:0]; req_remote = rem[0]; l2_state = l2[1:0];
        dir_state = dir[1:0]; dir_owner_hit = own[0];
        req_valid = 1'b1; dec_ready = 1'b0;
        check(req_ready == 1'b1, "R1 ready-idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(dec_valid == 1'b1, "R1 valid-next", int'(dec_valid), 1);
        check(req_ready == 1'b0, "R1 ready-busy", int'(req_ready), 0);
        check(dec_rd_amt == e[5:4], rtag, int'(dec_rd_amt), int'(e[5:4]));
        check(dec_wr_kind == e[3:2], wr_tag(k, rem, l2, dir), int'(dec_wr_kind), int'(e[3:2]));
        check(dec_drop == e[0], wr_tag(k, rem, l2, dir), int'(dec_drop), int'(e[0]));
        check(dec_l2_data == e[1], "R11", int'(dec_l2_data), int'(e[1]));
        got = {dec_rd_amt, dec_wr_kind, dec_l2_data, dec_drop};
        for (int s = 0; s < stall; s++) begin
            req_kind = 3'(k + 1); l2_state = 2'(l2 + 1);
            @(negedge clk);
            check(dec_valid && ({dec_rd_amt, dec_wr_kind, dec_l2_data, dec_drop} == got),
                  "R2 hold", int'({dec_rd_amt, dec_wr_kind, dec_l2_data, dec_drop}), int'(got));
        end
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
        check(dec_valid == 1'b0, "R1 consumed", int'(dec_valid), 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R13 reset valid", int'(dec_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(dec_valid == 1'b0, "R13 idle valid", int'(dec_valid), 0);
        check(req_ready == 1'b1, "R13 idle ready", int'(req_ready), 1);

        // directed corners
        run_vec(2, 1, 1, 3, 0, 2);   // R9 remote EX race
        run_vec(2, 0, 0, 3, 0, 0);   // R9 local EX race
        run_vec(4, 1, 1, 3, 1, 1);   // R10 owner writeback
        run_vec(4, 1, 1, 3, 0, 0);   // R10 non-owner drop
        run_vec(4, 1, 2, 3, 1, 0);   // R3 node-exclusive hides owner
        run_vec(0, 1, 0, 1, 0, 3);   // R7 shared read
        run_vec(6, 1, 1, 2, 1, 0);   // R12 reserved

        // exhaustive sweep
        for (int k = 0; k < 8; k++)
            for (int r = 0; r < 2; r++)
                for (int l = 0; l < 4; l++)
                    for (int d = 0; d < 4; d++)
                        for (int o = 0; o < 2; o++)
                            run_vec(k, r, l, d, o, 0);

        // random mix with backpressure
        for (int i = 0; i < 800; i++)
            run_vec(int'($urandom % 8), int'($urandom % 2), int'($urandom % 4),
                    int'($urandom % 4), int'($urandom % 2), int'($urandom % 4));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule